// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a clocked on-chip memory. It accepts a fresh read or write command on every rising clock edge, in any mix and order, and never asks for an idle cycle when the traffic switches between reading and writing. A command is captured together with its address. The data that belongs to it crosses the bus exactly two edges later. For a write, the data is sampled from `dq_in`. For a read, the data is driven on `dq_out` with `dq_oe` raised.

Write data arrives late, so the array update is also deferred. The word sits for one cycle in a write buffer before it is committed. Any read of that address during that cycle takes the buffered lanes in place of the array contents. A global stall input freezes the whole pipeline. Three select inputs gate the start of new commands. A load/continue input either starts a command at an external address or continues the previous command through a wrapping 4-word linear burst. The word is 36 bits: four lanes of 9 bits, each with its own write enable.

Top module: `zbt_sram`

## Requirements
- R1: A command accepted on edge N moves its data at edge N+2. A write samples `dq_in` at that edge. A read shows its word on `dq_out` and raises `dq_oe` (with `out_en` high) right after that edge. The word is held until the next read completes.
- R2: Commands may be accepted on consecutive edges in any read/write order. Every read returns the contents left by all writes accepted before it, including a write whose data arrived only one edge earlier.
- R3: With `adv` low, `is_read`=1 makes the accepted command a read and `is_read`=0 makes it a write.
- R4: While `freeze` is high at an edge, every input is ignored and no internal state changes at that edge, so `dq_out` and `dq_oe` keep their values (with `out_en` unchanged).
- R5: With `adv` low, a command starts only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination starts nothing, and two edges later `dq_oe` is low.
- R6: Commands accepted before a deselect still complete their data transfer.
- R7: Two edges after a write command or a deselect is accepted, `dq_oe` drops. Two edges after a read command is accepted, `dq_oe` follows `out_en`.
- R8: `out_en` low forces `dq_oe` low at once, whatever the pipeline holds.
- R9: On a write, bit i of `lane_we` updates only lane i (data bits 9i+8 to 9i). Lanes whose bit is 0 keep their old contents. `lane_we` has no effect on reads.
- R10: With `adv` high after an accepted load, a new command of the same type is issued. Its address keeps the upper address bits of the load and sets the low 2 bits to (load low bits + k) mod 4 on the k-th continuation. With `adv` high and no accepted load open (after a deselect), nothing starts.
- R11: After reset, `dq_oe` and `dq_out` are 0 and every memory word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | High stalls the whole pipeline |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| adv | input | 1 | 0 loads a new address, 1 continues the burst |
| is_read | input | 1 | 1 read, 0 write (sampled on load) |
| addr | input | 8 | Word address |
| lane_we | input | 4 | Per-lane write enables, sampled with the command |
| out_en | input | 1 | Asynchronous output enable |
| dq_in | input | 36 | Write data, sampled two edges after the command |
| dq_out | output | 36 | Read data |
| dq_oe | output | 1 | Output driver enable for the data bus |

## Verification
Two things can coincide in one cycle here: a read of an address reaching the array, and the commit of a buffered write to that same address. This happens when a read is accepted on the edge right after a write to the same word. The random traffic is confined to sixteen addresses with random lane masks to provoke it often, and directed write-then-read pairs force it with partial lanes. Each returned word is judged against a bench memory that applies every write in command order the moment its data arrives. A stale array word or a wrong lane choice therefore shows up as a mismatch.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    localparam int ADDR_W  = 8;
    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int BURST_W = 2;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [LANES-1:0]   lane_t;
    typedef logic [BURST_W-1:0] bcnt_t;

    // One command travelling through the pipeline
    typedef struct packed {
        logic  vld;
        logic  wr;
        addr_t addr;
        lane_t lanes;
    } op_t;

    // Write whose data has arrived but is not yet in the array
    typedef struct packed {
        logic  vld;
        addr_t addr;
        lane_t lanes;
        word_t data;
    } wbuf_t;

    function automatic word_t lane_merge(input word_t old_w, input word_t new_w, input lane_t en);
        word_t r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (en[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/zbt_cmd.sv
module zbt_cmd
    import zbt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  freeze,
    input  logic  sel_a_n,
    input  logic  sel_b,
    input  logic  sel_c_n,
    input  logic  adv,
    input  logic  is_read,
    input  addr_t addr,
    input  lane_t lane_we,
    output op_t   exec_op
);
    op_t   stage1_q, stage2_q, nxt_op;
    logic  ctx_act, ctx_wr;
    addr_t ctx_base;
    bcnt_t ctx_cnt, nxt_cnt, burst_lo;
    logic  sel_ok;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    always_comb begin
        nxt_cnt  = ctx_cnt + bcnt_t'(1);
        burst_lo = ctx_base[BURST_W-1:0] + nxt_cnt;
        nxt_op   = '0;
        if (!adv) begin
            nxt_op.vld  = sel_ok;
            nxt_op.wr   = !is_read;
            nxt_op.addr = addr;
        end else begin
            nxt_op.vld  = ctx_act;
            nxt_op.wr   = ctx_wr;
            nxt_op.addr = {ctx_base[ADDR_W-1:BURST_W], burst_lo};
        end
        nxt_op.lanes = nxt_op.wr ? lane_we : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            ctx_act  <= 1'b0;
            ctx_wr   <= 1'b0;
            ctx_base <= '0;
            ctx_cnt  <= '0;
        end else if (!freeze) begin
            stage1_q <= nxt_op;
            stage2_q <= stage1_q;
            if (!adv) begin
                ctx_act  <= sel_ok;
                ctx_wr   <= !is_read;
                ctx_base <= addr;
                ctx_cnt  <= '0;
            end else if (ctx_act) begin
                ctx_cnt  <= nxt_cnt;
            end
        end
    end

    assign exec_op = stage2_q;
endmodule

// File: rtl/zbt_store.sv
module zbt_store
    import zbt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  freeze,
    input  op_t   exec_op,
    input  word_t wr_data,
    output word_t rd_word,
    output logic  rd_vld
);
    word_t mem [DEPTH];
    wbuf_t wb_q;
    word_t arr_word, fwd_word;
    lane_t hit_lane;
    logic  do_read;

    assign arr_word = mem[exec_op.addr];
    assign do_read  = exec_op.vld && !exec_op.wr;

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign hit_lane[g] = wb_q.vld && (wb_q.addr == exec_op.addr) && wb_q.lanes[g];
        assign fwd_word[g*LANE_W +: LANE_W] = hit_lane[g] ? wb_q.data[g*LANE_W +: LANE_W]
                                                          : arr_word[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (!freeze && wb_q.vld) begin
            mem[wb_q.addr] <= lane_merge(mem[wb_q.addr], wb_q.data, wb_q.lanes);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '0;
        end else if (!freeze) begin
            wb_q.vld   <= exec_op.vld && exec_op.wr;
            wb_q.addr  <= exec_op.addr;
            wb_q.lanes <= exec_op.lanes;
            wb_q.data  <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld  <= 1'b0;
            rd_word <= '0;
        end else if (!freeze) begin
            rd_vld <= do_read;
            if (do_read) rd_word <= fwd_word;
        end
    end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                freeze,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                adv,
    input  logic                is_read,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LANES-1:0]    lane_we,
    input  logic                out_en,
    input  logic [WORD_W-1:0]   dq_in,
    output logic [WORD_W-1:0]   dq_out,
    output logic                dq_oe
);
    op_t   exec_op;
    word_t rd_word;
    logic  rd_vld;

    zbt_cmd u_cmd (
        .clk     (clk),
        .rst     (rst),
        .freeze  (freeze),
        .sel_a_n (sel_a_n),
        .sel_b   (sel_b),
        .sel_c_n (sel_c_n),
        .adv     (adv),
        .is_read (is_read),
        .addr    (addr),
        .lane_we (lane_we),
        .exec_op (exec_op)
    );

    zbt_store u_store (
        .clk     (clk),
        .rst     (rst),
        .freeze  (freeze),
        .exec_op (exec_op),
        .wr_data (dq_in),
        .rd_word (rd_word),
        .rd_vld  (rd_vld)
    );

    assign dq_out = rd_word;
    assign dq_oe  = out_en && rd_vld;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
    import zbt_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  freeze,
    input logic  sel_a_n,
    input logic  sel_b,
    input logic  sel_c_n,
    input logic  adv,
    input logic  is_read,
    input logic  out_en,
    input word_t dq_out,
    input logic  dq_oe
);
    logic sel_ok;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    AST_OUT_EN_FORCE: assert property (@(posedge clk) disable iff (rst) !out_en |-> !dq_oe); // R8
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst) freeze |=> $stable(dq_out)); // R4
    AST_WRITE_OFF: assert property (@(posedge clk) disable iff (rst) (!freeze && !adv && sel_ok && !is_read) ##1 !freeze ##1 !freeze |=> !dq_oe); // R7
    AST_DESELECT_OFF: assert property (@(posedge clk) disable iff (rst) (!freeze && !adv && !sel_ok) ##1 !freeze ##1 !freeze |=> !dq_oe); // R5
    AST_READ_DRIVE: assert property (@(posedge clk) disable iff (rst) (!freeze && !adv && sel_ok && is_read) ##1 !freeze ##1 !freeze |=> (dq_oe == out_en)); // R1
endmodule

bind zbt_sram zbt_sram_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .freeze  (freeze),
    .sel_a_n (sel_a_n),
    .sel_b   (sel_b),
    .sel_c_n (sel_c_n),
    .adv     (adv),
    .is_read (is_read),
    .out_en  (out_en),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
);

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        freeze = 1'b0;
    logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic        adv = 1'b0, is_read = 1'b0;
    logic [7:0]  addr = '0;
    logic [3:0]  lane_we = '0;
    logic        out_en = 1'b1;
    logic [35:0] dq_in = '0;
    logic [35:0] dq_out;
    logic        dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference state
    logic [35:0] mem_m [256];
    logic        p1_v = 0, p1_w = 0, p2_v = 0, p2_w = 0;
    logic [7:0]  p1_a = '0, p2_a = '0;
    logic [3:0]  p1_l = '0, p2_l = '0;
    logic        b_act = 0, b_wr = 0;
    logic [7:0]  b_base = '0;
    logic [1:0]  b_cnt = '0;
    logic        exp_v = 0;
    logic [35:0] exp_w = '0;

    always #2 clk = ~clk;

    zbt_sram u_zbt_sram (
        .clk(clk), .rst(rst), .freeze(freeze),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .adv(adv), .is_read(is_read), .addr(addr), .lane_we(lane_we),
        .out_en(out_en), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [35:0] ref_write(input logic [35:0] old_w, input logic [35:0] new_w,
                                              input logic [3:0] en);
        logic [35:0] m;
        m = '0;
        for (int k = 0; k < 4; k++) if (en[k]) m = m | (36'h1FF << (9 * k));
        return (old_w & ~m) | (new_w & m);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // sel = {sel_a_n, sel_b, sel_c_n}; 3'b010 selects
    task automatic tick(input logic f, input logic [2:0] sel, input logic ad, input logic rd,
                        input logic [7:0] a, input logic [3:0] ln, input logic oe, input string tag);
        logic [35:0] wd;
        logic        nv, nw;
        logic [7:0]  na;
        logic [1:0]  nc, lo;
        wd = {4'($urandom()), $urandom()};
        nc = b_cnt + 2'd1;
        lo = b_base[1:0] + nc;
        if (!ad) begin
            nv = (sel == 3'b010); nw = !rd; na = a;
        end else begin
            nv = b_act; nw = b_wr; na = {b_base[7:2], lo};
        end
        freeze = f; {sel_a_n, sel_b, sel_c_n} = sel; adv = ad; is_read = rd;
        addr = a; lane_we = ln; out_en = oe; dq_in = wd;
        @(posedge clk);
        if (!f) begin
            if (p2_v && p2_w) mem_m[p2_a] = ref_write(mem_m[p2_a], wd, p2_l);
            exp_v = p2_v && !p2_w;
            if (exp_v) exp_w = mem_m[p2_a];
            if (!ad) begin
                b_act = (sel == 3'b010); b_wr = !rd; b_base = a; b_cnt = '0;
            end else if (b_act) begin
                b_cnt = nc;
            end
            p2_v = p1_v; p2_w = p1_w; p2_a = p1_a; p2_l = p1_l;
            p1_v = nv; p1_w = nw; p1_a = na; p1_l = nw ? ln : 4'h0;
        end
        @(negedge clk);
        if (!oe) check("R8 oe forced off", 64'(dq_oe), 64'(0));
        else     check({tag, " oe"}, 64'(dq_oe), 64'(exp_v));
        check({tag, " data"}, 64'(dq_out), 64'(exp_w));
    endtask

    task automatic idle(input string tag);
        tick(1'b0, 3'b000, 1'b0, 1'b1, 8'h00, 4'h0, 1'b1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 256; i++) mem_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R11 reset oe", 64'(dq_oe), 64'(0));
        check("R11 reset data", 64'(dq_out), 64'(0));

        // R11: untouched word reads zero
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd50, 4'h0, 1'b1, "R11");
        idle("R11"); idle("R11");

        // R3 R1 R2: write then read same word on the next edge (forwarding)
        tick(1'b0, 3'b010, 1'b0, 1'b0, 8'd3, 4'hF, 1'b1, "R3");
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd3, 4'h0, 1'b1, "R2");
        tick(1'b0, 3'b010, 1'b0, 1'b0, 8'd4, 4'hF, 1'b1, "R1");
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd4, 4'h0, 1'b1, "R2");
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd3, 4'hF, 1'b1, "R9");
        idle("R7"); idle("R7");

        // R9: partial lanes, then read while buffered
        tick(1'b0, 3'b010, 1'b0, 1'b0, 8'd3, 4'b0101, 1'b1, "R9");
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd3, 4'hF, 1'b1, "R9");
        tick(1'b0, 3'b010, 1'b0, 1'b0, 8'd3, 4'b1000, 1'b1, "R9");
        tick(1'b0, 3'b010, 1'b0, 1'b0, 8'd3, 4'b0000, 1'b1, "R9");
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd3, 4'h0, 1'b1, "R9");
        idle("R9"); idle("R9");

        // R10: burst write from base 6, then burst read back
        tick(1'b0, 3'b010, 1'b0, 1'b0, 8'd6, 4'hF, 1'b1, "R10");
        for (int k = 0; k < 3; k++) tick(1'b0, 3'b000, 1'b1, 1'b1, 8'd99, 4'hF, 1'b1, "R10");
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd6, 4'h0, 1'b1, "R10");
        for (int k = 0; k < 5; k++) tick(1'b0, 3'b000, 1'b1, 1'b0, 8'd99, 4'hF, 1'b1, "R10");
        idle("R10");
        // R10: continue with no open load starts nothing
        for (int k = 0; k < 4; k++) tick(1'b0, 3'b010, 1'b1, 1'b1, 8'd7, 4'h0, 1'b1, "R10");

        // R5 R6: reads in flight complete across deselects
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd7, 4'h0, 1'b1, "R6");
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd4, 4'h0, 1'b1, "R6");
        tick(1'b0, 3'b110, 1'b0, 1'b1, 8'd5, 4'h0, 1'b1, "R6");
        tick(1'b0, 3'b011, 1'b0, 1'b1, 8'd5, 4'h0, 1'b1, "R5");
        tick(1'b0, 3'b000, 1'b0, 1'b1, 8'd5, 4'h0, 1'b1, "R5");

        // R4: freeze with a read in flight and junk commands presented
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd6, 4'h0, 1'b1, "R4");
        tick(1'b0, 3'b010, 1'b0, 1'b0, 8'd6, 4'hF, 1'b1, "R4");
        for (int k = 0; k < 4; k++) tick(1'b1, 3'b010, 1'b0, 1'b0, 8'd6, 4'hF, 1'b1, "R4");
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd6, 4'h0, 1'b1, "R4");
        for (int k = 0; k < 2; k++) tick(1'b1, 3'b000, 1'b0, 1'b1, 8'd0, 4'h0, 1'b1, "R4");
        idle("R4"); idle("R4"); idle("R4");

        // R8: output enable low while read data is valid
        tick(1'b0, 3'b010, 1'b0, 1'b1, 8'd6, 4'h0, 1'b1, "R8");
        idle("R8");
        tick(1'b0, 3'b000, 1'b0, 1'b1, 8'd0, 4'h0, 1'b0, "R8");

        // R2: random mixed traffic over a small address window
        for (int i = 0; i < 1500; i++) begin
            logic [2:0] s;
            s = ($urandom_range(9, 0) == 0) ? 3'($urandom_range(7, 0)) : 3'b010;
            tick($urandom_range(9, 0) == 0, s, $urandom_range(4, 0) == 0,
                 1'($urandom_range(1, 0)), 8'($urandom_range(15, 0)),
                 4'($urandom_range(15, 0)), $urandom_range(19, 0) != 0, "R2");
        end
        idle("R2"); idle("R2");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule